// File: doc/BRIEF.md
# Intra 4x4 Luma Predictor and Mode Selector

This block chooses the best spatial prediction for one 4x4 block of luma samples. It takes the thirteen reconstructed samples that border the block (four above, four above-right, four to the left and the one at the upper-left corner), four flags saying which of those groups may be used, and the sixteen source samples of the block. It forms the prediction for all nine directional and flat modes at once and scores each one by the sum of absolute differences against the source. It then reports the cheapest mode and its cost.

The predictors are not built as nine separate circuits. One layer of adders forms every rounded sum of two neighbouring border samples. A second layer adds pairs of those sums to get every rounded three-tap smoothing term, plus the two end terms and the flat average. A fixed routing step then places these shared terms at each pixel of each mode. The block is fully pipelined: a new 4x4 block may start on every clock cycle, and each result follows after a fixed latency.

Top module: `intra4_mode_decide`

## Requirements
- R1: `done` is high for exactly one cycle for each cycle in which `start` is high. It rises on the fifth rising clock edge counted from, and including, the edge that samples `start`. Starts on consecutive cycles produce results on consecutive cycles, in order.
- R2: Mode 0 (vertical) predicts pixel (x,y) as the above sample x. Mode 1 (horizontal) predicts it as left sample y. Pixel (x,y) sits at bits [(4y+x)*8 +: 8] of `src_blk`. Above sample k and left sample k sit at bits [k*8 +: 8] of their buses.
- R3: Mode 2 (flat) with both the above and left groups available predicts every pixel as (sum of the four above + sum of the four left + 4) >> 3.
- R4: Mode 2 with only one of those two groups available uses (sum of its four samples + 2) >> 2. With neither available it predicts 128.
- R5: Modes 3 to 8 follow the standard diagonal-down-left, diagonal-down-right, vertical-right, horizontal-down, vertical-left and horizontal-up rules. Two-tap terms are (a+b+1)>>1 and three-tap terms are (a+2b+c+2)>>2. Diagonal-down-left pixel (3,3) is (G+3H+2)>>2. Horizontal-up pixel (1,2) is (K+3L+2)>>2, and its pixels (2,2), (3,2) and row 3 equal L.
- R6: A mode is usable only when its groups are available. Modes 0 and 3/7 need above, and 3/7 also need above-right. Modes 1 and 8 need left. Modes 4, 5 and 6 need above, left and corner. Mode 2 is always usable. An unusable mode gets cost 4095 and is never chosen over a usable one.
- R7: `best_sad` is the smallest of the nine costs, and `best_mode` (0 to 8) is its mode. On a tie the lower mode number wins.
- R8: After reset `best_mode`, `best_sad` and `done` are 0. Between `done` pulses both result outputs hold their last value.
- R9: Border samples in a group whose flag is low have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Sample the inputs and begin a block |
| nb_top | input | 4*PIX_W | Above samples A..D, A in the low bits |
| nb_topright | input | 4*PIX_W | Above-right samples E..H, E in the low bits |
| nb_left | input | 4*PIX_W | Left samples I..L, I (top row) in the low bits |
| nb_corner | input | PIX_W | Upper-left corner sample |
| avail_top | input | 1 | Above group usable |
| avail_topright | input | 1 | Above-right group usable |
| avail_left | input | 1 | Left group usable |
| avail_corner | input | 1 | Corner sample usable |
| src_blk | input | 16*PIX_W | Source block, raster order |
| best_mode | output | 4 | Chosen mode number |
| best_sad | output | PIX_W+4 | Cost of the chosen mode |
| done | output | 1 | Result valid pulse |

## Verification
Every result is due five rising edges after the edge that takes `start`. One edge registers the predictions, two the row sums and the totals, and two the group minima and the final minimum. When the driver raises `start`, it pushes the expected mode and cost into a queue together with the cycle index in which `done` must show. The monitor samples on the falling edge. It checks that each `done` lands exactly in the due cycle, and it reports as late any entry whose cycle passes without one. On every other falling edge it checks that the outputs have held still.

// File: rtl/intra4_pkg.sv
package intra4_pkg;
   localparam int NMODES = 9;
   localparam int NPIX   = 16;
   localparam int NEDGE  = 13;

   // source kinds of a routed predicted pixel
   localparam logic [1:0] K_COPY  = 2'd0;
   localparam logic [1:0] K_TWO   = 2'd1;
   localparam logic [1:0] K_THREE = 2'd2;
   localparam logic [1:0] K_DC    = 2'd3;

   // Border line e[0..12] = L3 L2 L1 L0 M A B C D E F G H.
   // K_TWO idx i   : rounded mean of e[i], e[i+1]
   // K_THREE idx c : smoothing centred on e[c] (ends use the doubled end sample)
   function automatic logic [5:0] route(input int mode, input int x, input int y);
      int kind;
      int idx;
      int z;
      int b;
      kind = 0;
      idx  = 0;
      case (mode)
         0: begin kind = 0; idx = 5 + x; end
         1: begin kind = 0; idx = 3 - y; end
         2: begin kind = 3; idx = 0; end
         3: begin kind = 2; idx = 6 + x + y; end
         4: begin kind = 2; idx = 4 + x - y; end
         5: begin
            z = 2 * x - y;
            if (z >= 0 && (z % 2) == 0) begin kind = 1; idx = 4 + x - (y >> 1); end
            else if (z > 0)             begin kind = 2; idx = 4 + x - (y >> 1); end
            else if (z == -1)           begin kind = 2; idx = 4; end
            else                        begin kind = 2; idx = 5 - y; end
         end
         6: begin
            z = 2 * y - x;
            if (z >= 0 && (z % 2) == 0) begin kind = 1; idx = 3 - y + (x >> 1); end
            else if (z > 0)             begin kind = 2; idx = 4 - y + (x >> 1); end
            else if (z == -1)           begin kind = 2; idx = 4; end
            else                        begin kind = 2; idx = 3 + x; end
         end
         7: begin
            if ((y % 2) == 0) begin kind = 1; idx = 5 + x + (y >> 1); end
            else              begin kind = 2; idx = 6 + x + (y >> 1); end
         end
         default: begin
            z = x + 2 * y;
            b = y + (x >> 1);
            if (z > 5)              begin kind = 0; idx = 0; end
            else if ((z % 2) == 0)  begin kind = 1; idx = 2 - b; end
            else                    begin kind = 2; idx = 2 - b; end
         end
      endcase
      return {kind[1:0], idx[3:0]};
   endfunction
endpackage

// File: rtl/intra4_pred.sv
module intra4_pred
   import intra4_pkg::*;
#(
   parameter int PIX_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [4*PIX_W-1:0]            nb_top,
   input  logic [4*PIX_W-1:0]            nb_topright,
   input  logic [4*PIX_W-1:0]            nb_left,
   input  logic [PIX_W-1:0]              nb_corner,
   input  logic [3:0]                    avail,      // 0 top, 1 top-right, 2 left, 3 corner
   input  logic [NPIX*PIX_W-1:0]         src_blk,
   output logic                          pred_vld,
   output logic [NMODES*NPIX*PIX_W-1:0]  pred_q,
   output logic [NPIX*PIX_W-1:0]         src_q,
   output logic [NMODES-1:0]             mode_ok_q
);
   localparam logic [PIX_W-1:0] MID = PIX_W'(1 << (PIX_W - 1));

   logic [PIX_W-1:0]   nbr  [NEDGE];
   logic [PIX_W:0]     pair [NEDGE-1];
   logic [PIX_W+1:0]   trip [NEDGE];
   logic [PIX_W:0]     end_hi, end_lo;
   logic [PIX_W+1:0]   s_top, s_left;
   logic [PIX_W+2:0]   s_all;
   logic [PIX_W-1:0]   dc_px;
   logic [NMODES*NPIX*PIX_W-1:0] pred_c;
   logic [NMODES-1:0]  ok_c;

   // border line
   assign nbr[4] = nb_corner;
   for (genvar k = 0; k < 4; k++) begin : g_line
      assign nbr[3-k] = nb_left[k*PIX_W +: PIX_W];
      assign nbr[5+k] = nb_top[k*PIX_W +: PIX_W];
      assign nbr[9+k] = nb_topright[k*PIX_W +: PIX_W];
   end

   // level 1: rounded pair sums
   for (genvar i = 0; i < NEDGE - 1; i++) begin : g_pair
      assign pair[i] = (PIX_W+1)'(nbr[i]) + (PIX_W+1)'(nbr[i+1]) + (PIX_W+1)'(1);
   end
   assign end_hi = {nbr[NEDGE-1], 1'b1};
   assign end_lo = {nbr[0], 1'b1};

   // level 2: three-tap terms from two pair sums
   for (genvar c = 0; c < NEDGE; c++) begin : g_trip
      if (c == 0) begin : g_lo
         assign trip[c] = (PIX_W+2)'(pair[0]) + (PIX_W+2)'(end_lo);
      end else if (c == NEDGE - 1) begin : g_hi
         assign trip[c] = (PIX_W+2)'(pair[NEDGE-2]) + (PIX_W+2)'(end_hi);
      end else begin : g_mid
         assign trip[c] = (PIX_W+2)'(pair[c-1]) + (PIX_W+2)'(pair[c]);
      end
   end

   // flat term: four-sample sums (+2 each) from pair sums
   assign s_top  = (PIX_W+2)'(pair[5]) + (PIX_W+2)'(pair[7]);
   assign s_left = (PIX_W+2)'(pair[0]) + (PIX_W+2)'(pair[2]);
   assign s_all  = (PIX_W+3)'(s_top) + (PIX_W+3)'(s_left);

   always_comb begin
      case ({avail[0], avail[2]})
         2'b11:   dc_px = s_all[PIX_W+2:3];
         2'b10:   dc_px = s_top[PIX_W+1:2];
         2'b01:   dc_px = s_left[PIX_W+1:2];
         default: dc_px = MID;
      endcase
   end

   // routing of shared terms to every pixel of every mode
   for (genvar m = 0; m < NMODES; m++) begin : g_mode
      for (genvar p = 0; p < NPIX; p++) begin : g_px
         localparam logic [5:0] RT  = route(m, p % 4, p / 4);
         localparam int         IDX = int'(RT[3:0]);
         if (RT[5:4] == K_COPY) begin : g_copy
            assign pred_c[(m*NPIX+p)*PIX_W +: PIX_W] = nbr[IDX];
         end else if (RT[5:4] == K_TWO) begin : g_two
            assign pred_c[(m*NPIX+p)*PIX_W +: PIX_W] = pair[IDX][PIX_W:1];
         end else if (RT[5:4] == K_THREE) begin : g_three
            assign pred_c[(m*NPIX+p)*PIX_W +: PIX_W] = trip[IDX][PIX_W+1:2];
         end else begin : g_dc
            assign pred_c[(m*NPIX+p)*PIX_W +: PIX_W] = dc_px;
         end
      end
   end

   // mode usability from neighbour groups
   always_comb begin
      ok_c    = '0;
      ok_c[0] = avail[0];
      ok_c[1] = avail[2];
      ok_c[2] = 1'b1;
      ok_c[3] = avail[0] & avail[1];
      ok_c[4] = avail[0] & avail[2] & avail[3];
      ok_c[5] = avail[0] & avail[2] & avail[3];
      ok_c[6] = avail[0] & avail[2] & avail[3];
      ok_c[7] = avail[0] & avail[1];
      ok_c[8] = avail[2];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pred_vld <= 1'b0;
      end else begin
         pred_vld <= start;
      end
      if (start) begin
         pred_q    <= pred_c;
         src_q     <= src_blk;
         mode_ok_q <= ok_c;
      end
   end
endmodule

// File: rtl/intra4_sad.sv
module intra4_sad
   import intra4_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int SAD_W = PIX_W + 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_vld,
   input  logic [NMODES*NPIX*PIX_W-1:0]  pred_q,
   input  logic [NPIX*PIX_W-1:0]         src_q,
   input  logic [NMODES-1:0]             mode_ok,
   output logic                          sad_vld,
   output logic [NMODES*SAD_W-1:0]       sad_flat
);
   localparam int ROW_W = PIX_W + 2;

   logic              vld_a;
   logic [NMODES-1:0] ok_a;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_a   <= 1'b0;
         sad_vld <= 1'b0;
      end else begin
         vld_a   <= in_vld;
         sad_vld <= vld_a;
      end
      if (in_vld) ok_a <= mode_ok;
   end

   for (genvar m = 0; m < NMODES; m++) begin : g_mode
      logic [ROW_W-1:0] row_c [4];
      logic [ROW_W-1:0] row_q [4];
      logic [PIX_W-1:0] a_px, b_px;
      logic [SAD_W-1:0] total, sad_q;

      // stage A: absolute differences summed per row
      always_comb begin
         a_px = '0;
         b_px = '0;
         for (int r = 0; r < 4; r++) begin
            row_c[r] = '0;
            for (int c = 0; c < 4; c++) begin
               a_px = pred_q[(m*NPIX + r*4 + c)*PIX_W +: PIX_W];
               b_px = src_q[(r*4 + c)*PIX_W +: PIX_W];
               row_c[r] = row_c[r] + ROW_W'((a_px > b_px) ? (a_px - b_px) : (b_px - a_px));
            end
         end
      end

      // stage B: block total, unusable modes pinned to the top value
      assign total = SAD_W'(row_q[0]) + SAD_W'(row_q[1]) + SAD_W'(row_q[2]) + SAD_W'(row_q[3]);

      always_ff @(posedge clk) begin
         if (in_vld) row_q <= row_c;
         if (vld_a)  sad_q <= ok_a[m] ? total : '1;
      end

      assign sad_flat[m*SAD_W +: SAD_W] = sad_q;
   end
endmodule

// File: rtl/intra4_pick.sv
module intra4_pick
   import intra4_pkg::*;
#(
   parameter int SAD_W = 12,
   parameter int GRP   = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld,
   input  logic [NMODES*SAD_W-1:0] sad_flat,
   output logic                    done,
   output logic [3:0]              best_mode,
   output logic [SAD_W-1:0]        best_sad
);
   localparam int NGRP = NMODES / GRP;

   logic                   vld_a;
   logic [NGRP*SAD_W-1:0]  grp_sad;
   logic [NGRP*4-1:0]      grp_idx;
   logic [SAD_W-1:0]       fin_sad;
   logic [3:0]             fin_idx;

   // stage A: winner inside each group, strict compare keeps lower index
   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      logic [SAD_W-1:0] w_sad, w_sad_q;
      logic [3:0]       w_idx, w_idx_q;
      always_comb begin
         w_sad = sad_flat[(g*GRP)*SAD_W +: SAD_W];
         w_idx = 4'(g*GRP);
         for (int k = 1; k < GRP; k++) begin
            if (sad_flat[(g*GRP+k)*SAD_W +: SAD_W] < w_sad) begin
               w_sad = sad_flat[(g*GRP+k)*SAD_W +: SAD_W];
               w_idx = 4'(g*GRP + k);
            end
         end
      end
      always_ff @(posedge clk) begin
         if (in_vld) begin
            w_sad_q <= w_sad;
            w_idx_q <= w_idx;
         end
      end
      assign grp_sad[g*SAD_W +: SAD_W] = w_sad_q;
      assign grp_idx[g*4 +: 4]         = w_idx_q;
   end

   // stage B: winner across groups, lower group first
   always_comb begin
      fin_sad = grp_sad[0 +: SAD_W];
      fin_idx = grp_idx[0 +: 4];
      for (int g = 1; g < NGRP; g++) begin
         if (grp_sad[g*SAD_W +: SAD_W] < fin_sad) begin
            fin_sad = grp_sad[g*SAD_W +: SAD_W];
            fin_idx = grp_idx[g*4 +: 4];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_a     <= 1'b0;
         done      <= 1'b0;
         best_mode <= '0;
         best_sad  <= '0;
      end else begin
         vld_a <= in_vld;
         done  <= vld_a;
         if (vld_a) begin
            best_mode <= fin_idx;
            best_sad  <= fin_sad;
         end
      end
   end
endmodule

// File: rtl/intra4_mode_decide.sv
module intra4_mode_decide
   import intra4_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int GRP   = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [4*PIX_W-1:0]      nb_top,
   input  logic [4*PIX_W-1:0]      nb_topright,
   input  logic [4*PIX_W-1:0]      nb_left,
   input  logic [PIX_W-1:0]        nb_corner,
   input  logic                    avail_top,
   input  logic                    avail_topright,
   input  logic                    avail_left,
   input  logic                    avail_corner,
   input  logic [16*PIX_W-1:0]     src_blk,
   output logic [3:0]              best_mode,
   output logic [PIX_W+3:0]        best_sad,
   output logic                    done
);
   localparam int SAD_W = PIX_W + 4;

   if (PIX_W < 4 || PIX_W > 12) begin : g_bad_width
      $error("intra4_mode_decide: PIX_W must lie in 4..12");
   end
   if (GRP < 1 || (NMODES % GRP) != 0) begin : g_bad_group
      $error("intra4_mode_decide: GRP must divide the mode count");
   end

   logic                          pred_vld, sad_vld;
   logic [NMODES*NPIX*PIX_W-1:0]  pred_q;
   logic [NPIX*PIX_W-1:0]         src_q;
   logic [NMODES-1:0]             mode_ok_q;
   logic [NMODES*SAD_W-1:0]       sad_flat;

   intra4_pred #(.PIX_W(PIX_W)) u_pred (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .nb_top      (nb_top),
      .nb_topright (nb_topright),
      .nb_left     (nb_left),
      .nb_corner   (nb_corner),
      .avail       ({avail_corner, avail_left, avail_topright, avail_top}),
      .src_blk     (src_blk),
      .pred_vld    (pred_vld),
      .pred_q      (pred_q),
      .src_q       (src_q),
      .mode_ok_q   (mode_ok_q)
   );

   intra4_sad #(.PIX_W(PIX_W), .SAD_W(SAD_W)) u_sad (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (pred_vld),
      .pred_q   (pred_q),
      .src_q    (src_q),
      .mode_ok  (mode_ok_q),
      .sad_vld  (sad_vld),
      .sad_flat (sad_flat)
   );

   intra4_pick #(.SAD_W(SAD_W), .GRP(GRP)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vld    (sad_vld),
      .sad_flat  (sad_flat),
      .done      (done),
      .best_mode (best_mode),
      .best_sad  (best_sad)
   );
endmodule

// File: rtl/intra4_chk.sv
module intra4_chk #(
   parameter int PIX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             avail_top,
   input logic             avail_left,
   input logic             done,
   input logic [3:0]       best_mode,
   input logic [PIX_W+3:0] best_sad
);
   localparam int MAXS = 16 * ((1 << PIX_W) - 1);

   logic [3:0] since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
   end

   // R1: result pulse tracks start with fixed latency
   a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 4'd5) |-> (done == $past(start, 5)));

   // R4, R6: no side available leaves only the flat mode
   a_r6_flat_only: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 4'd5 && done && $past(!avail_top && !avail_left, 5)) |-> (best_mode == 4'd2));

   // R7: mode number in range
   a_r7_mode_range: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (best_mode <= 4'd8));

   // R7: winner never worse than the always-usable flat mode bound
   a_r7_sad_bound: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (best_sad <= (PIX_W+4)'(MAXS)));

   // R8: results hold between pulses
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 4'd1 && !done) |-> ($stable(best_mode) && $stable(best_sad)));
endmodule

bind intra4_mode_decide intra4_chk #(.PIX_W(PIX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .avail_top  (avail_top),
   .avail_left (avail_left),
   .done       (done),
   .best_mode  (best_mode),
   .best_sad   (best_sad)
);

// File: tb/intra4_mode_decide_tb.sv
`timescale 1ns/1ps
module intra4_mode_decide_tb;
   localparam int W = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [4*W-1:0]  nb_top = '0, nb_topright = '0, nb_left = '0;
   logic [W-1:0]    nb_corner = '0;
   logic            avail_top = 1'b0, avail_topright = 1'b0, avail_left = 1'b0, avail_corner = 1'b0;
   logic [16*W-1:0] src_blk = '0;
   logic [3:0]      best_mode;
   logic [W+3:0]    best_sad;
   logic            done;

   always #2.5 clk = ~clk;   // 200 MHz

   intra4_mode_decide #(.PIX_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .nb_top(nb_top), .nb_topright(nb_topright), .nb_left(nb_left), .nb_corner(nb_corner),
      .avail_top(avail_top), .avail_topright(avail_topright),
      .avail_left(avail_left), .avail_corner(avail_corner),
      .src_blk(src_blk), .best_mode(best_mode), .best_sad(best_sad), .done(done)
   );

   typedef struct {
      int     mode;
      int     sad;
      longint due;
      string  tag;
   } exp_t;

   exp_t   sb[$];
   longint cyc = 0;
   int     checks = 0, errors = 0;
   bit     ended = 1'b0;
   int     last_mode = 0, last_sad = 0;

   int top_a[8];
   int left_a[4];
   int corner_v;
   int src_a[16];
   bit av_t, av_tr, av_l, av_c;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int t2f(int a, int b);
      return (a + b + 1) >> 1;
   endfunction
   function automatic int t3f(int a, int b, int c);
      return (a + 2*b + c + 2) >> 2;
   endfunction
   function automatic int tk(int k);
      return (k < 0) ? corner_v : top_a[k];
   endfunction
   function automatic int lk(int k);
      return (k < 0) ? corner_v : left_a[k];
   endfunction

   function automatic int ref_dc();
      int st, sl;
      st = top_a[0] + top_a[1] + top_a[2] + top_a[3];
      sl = left_a[0] + left_a[1] + left_a[2] + left_a[3];
      if (av_t && av_l) return (st + sl + 4) >> 3;
      if (av_t)         return (st + 2) >> 2;
      if (av_l)         return (sl + 2) >> 2;
      return 128;
   endfunction

   function automatic int ref_px(int m, int x, int y);
      int z;
      case (m)
         0: return top_a[x];
         1: return left_a[y];
         2: return ref_dc();
         3: begin
            if (x == 3 && y == 3) return (top_a[6] + 3*top_a[7] + 2) >> 2;
            return t3f(top_a[x+y], top_a[x+y+1], top_a[x+y+2]);
         end
         4: begin
            if (x > y) return t3f(tk(x-y-2), tk(x-y-1), tk(x-y));
            if (x < y) return t3f(lk(y-x-2), lk(y-x-1), lk(y-x));
            return t3f(top_a[0], corner_v, left_a[0]);
         end
         5: begin
            z = 2*x - y;
            if (z >= 0 && z % 2 == 0) return t2f(tk(x-(y>>1)-1), tk(x-(y>>1)));
            if (z > 0)  return t3f(tk(x-(y>>1)-2), tk(x-(y>>1)-1), tk(x-(y>>1)));
            if (z == -1) return t3f(left_a[0], corner_v, top_a[0]);
            return t3f(lk(y-1), lk(y-2), lk(y-3));
         end
         6: begin
            z = 2*y - x;
            if (z >= 0 && z % 2 == 0) return t2f(lk(y-(x>>1)-1), lk(y-(x>>1)));
            if (z > 0)  return t3f(lk(y-(x>>1)-2), lk(y-(x>>1)-1), lk(y-(x>>1)));
            if (z == -1) return t3f(left_a[0], corner_v, top_a[0]);
            return t3f(tk(x-1), tk(x-2), tk(x-3));
         end
         7: begin
            if (y == 0) return t2f(top_a[x], top_a[x+1]);
            if (y == 1) return t3f(top_a[x], top_a[x+1], top_a[x+2]);
            if (y == 2) return t2f(top_a[x+1], top_a[x+2]);
            return t3f(top_a[x+1], top_a[x+2], top_a[x+3]);
         end
         default: begin
            z = x + 2*y;
            if (z > 5)  return left_a[3];
            if (z == 5) return t3f(left_a[2], left_a[3], left_a[3]);
            if (z % 2 == 0) return t2f(lk(y+(x>>1)), lk(y+(x>>1)+1));
            return t3f(lk(y+(x>>1)), lk(y+(x>>1)+1), lk(y+(x>>1)+2));
         end
      endcase
   endfunction

   function automatic bit ref_ok(int m);
      case (m)
         0:       return av_t;
         1, 8:    return av_l;
         2:       return 1'b1;
         3, 7:    return av_t && av_tr;
         default: return av_t && av_l && av_c;
      endcase
   endfunction

   task automatic fill_src(int m);
      for (int y = 0; y < 4; y++)
         for (int x = 0; x < 4; x++)
            src_a[y*4+x] = ref_px(m, x, y);
   endtask

   task automatic rnd_all();
      for (int k = 0; k < 8; k++) top_a[k] = $urandom_range(0, 255);
      for (int k = 0; k < 4; k++) left_a[k] = $urandom_range(0, 255);
      corner_v = $urandom_range(0, 255);
      for (int k = 0; k < 16; k++) src_a[k] = $urandom_range(0, 255);
   endtask

   task automatic set_av(bit t, bit tr, bit l, bit c);
      av_t = t; av_tr = tr; av_l = l; av_c = c;
   endtask

   // driver: computes the expectation, pushes it, raises start
   task automatic run_case(string tag);
      exp_t e;
      int   s, d;
      @(negedge clk);
      e.mode = 0;
      e.sad  = 1 << 30;
      for (int m = 0; m < 9; m++) begin
         s = 0;
         for (int y = 0; y < 4; y++)
            for (int x = 0; x < 4; x++) begin
               d = ref_px(m, x, y) - src_a[y*4+x];
               s += (d < 0) ? -d : d;
            end
         if (!ref_ok(m)) s = 4095;
         if (s < e.sad) begin
            e.sad  = s;
            e.mode = m;
         end
      end
      e.due = cyc + 5;
      e.tag = tag;
      for (int k = 0; k < 4; k++) begin
         nb_top[k*W +: W]      = W'(top_a[k]);
         nb_topright[k*W +: W] = W'(top_a[k+4]);
         nb_left[k*W +: W]     = W'(left_a[k]);
      end
      nb_corner = W'(corner_v);
      for (int k = 0; k < 16; k++) src_blk[k*W +: W] = W'(src_a[k]);
      avail_top = av_t; avail_topright = av_tr; avail_left = av_l; avail_corner = av_c;
      start = 1'b1;
      sb.push_back(e);
   endtask

   task automatic idle(int n);
      @(negedge clk);
      start = 1'b0;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic report();
      if (!ended) begin
         ended = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // monitor: compares results in the cycle they are due
   always @(negedge clk) begin
      if (rst_n && !ended) begin
         if (done) begin
            checks++;
            if (sb.size() == 0) begin
               errors++;
               $display("FAIL R1 unexpected done: actual=1 expected=0 at cycle %0d", cyc);
            end else begin
               exp_t e;
               e = sb.pop_front();
               if (cyc != e.due) begin
                  errors++;
                  $display("FAIL R1 latency (%s): actual cycle=%0d expected=%0d", e.tag, cyc, e.due);
               end
               checks++;
               if (int'(best_mode) != e.mode || int'(best_sad) != e.sad) begin
                  errors++;
                  $display("FAIL %s: actual mode=%0d sad=%0d expected mode=%0d sad=%0d",
                           e.tag, best_mode, best_sad, e.mode, e.sad);
               end
               last_mode = int'(best_mode);
               last_sad  = int'(best_sad);
            end
         end else begin
            if (sb.size() > 0 && cyc > sb[0].due) begin
               exp_t e;
               e = sb.pop_front();
               checks++;
               errors++;
               $display("FAIL R1 late (%s): actual=no done expected at cycle %0d", e.tag, e.due);
            end
            checks++;   // R8: outputs hold between pulses
            if (int'(best_mode) != last_mode || int'(best_sad) != last_sad) begin
               errors++;
               $display("FAIL R8 hold: actual mode=%0d sad=%0d expected mode=%0d sad=%0d",
                        best_mode, best_sad, last_mode, last_sad);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         report();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;   // R8 reset state
      if (best_mode != 4'd0 || best_sad != '0 || done != 1'b0) begin
         errors++;
         $display("FAIL R8 reset: actual mode=%0d sad=%0d done=%0d expected 0 0 0",
                  best_mode, best_sad, done);
      end

      // R2 vertical and horizontal copies
      rnd_all(); set_av(1, 1, 1, 1); fill_src(0); run_case("R2 vertical");
      rnd_all(); set_av(1, 1, 1, 1); fill_src(1); run_case("R2 horizontal");
      idle(8);

      // R3 flat with both sides
      rnd_all(); set_av(1, 1, 1, 1);
      for (int k = 0; k < 4; k++) begin top_a[k] = 90; left_a[k] = 111; end
      for (int k = 0; k < 16; k++) src_a[k] = 101;
      run_case("R3 flat both sides");
      idle(8);

      // R4 single side and no side
      rnd_all(); set_av(1, 0, 0, 0); fill_src(2); run_case("R4 flat top only");
      rnd_all(); set_av(0, 0, 1, 0); fill_src(2); run_case("R4 flat left only");
      rnd_all(); set_av(0, 0, 0, 0); run_case("R4 no side 128");
      idle(8);

      // R5 directional modes, source equal to each prediction
      for (int m = 3; m < 9; m++) begin
         rnd_all(); set_av(1, 1, 1, 1); fill_src(m); run_case("R5 directional");
      end
      idle(8);

      // R6 unusable modes lose to usable ones
      rnd_all(); set_av(1, 1, 1, 0); fill_src(4); run_case("R6 corner missing");
      rnd_all(); set_av(1, 0, 1, 1); fill_src(3); run_case("R6 top-right missing");
      rnd_all(); set_av(0, 1, 1, 1); fill_src(0); run_case("R6 top missing");
      idle(8);

      // R7 ties go to the lowest mode
      rnd_all(); set_av(1, 1, 1, 1);
      for (int k = 0; k < 8; k++) top_a[k] = 77;
      for (int k = 0; k < 4; k++) left_a[k] = 77;
      corner_v = 77;
      for (int k = 0; k < 16; k++) src_a[k] = 77;
      run_case("R7 all tie");
      rnd_all(); set_av(0, 0, 1, 0);
      for (int k = 0; k < 4; k++) left_a[k] = 40;
      for (int k = 0; k < 16; k++) src_a[k] = 40;
      run_case("R7 tie left only");
      idle(8);

      // R9 garbage in unavailable groups must not matter
      rnd_all(); set_av(1, 0, 0, 0);
      for (int k = 0; k < 4; k++) left_a[k] = 0;
      corner_v = 0; for (int k = 4; k < 8; k++) top_a[k] = 0;
      run_case("R9 masked zeros");
      for (int k = 0; k < 4; k++) left_a[k] = 255;
      corner_v = 255; for (int k = 4; k < 8; k++) top_a[k] = 255;
      run_case("R9 masked ones");
      idle(8);

      // R1 back-to-back random blocks
      for (int n = 0; n < 40; n++) begin
         rnd_all();
         set_av(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
         if (n % 3 == 0) fill_src($urandom_range(0, 8));
         run_case("R1 back-to-back");
      end
      idle(12);

      checks++;   // R1: every expected result arrived
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R1 pending: actual=%0d left expected=0", sb.size());
      end
      report();
   end
endmodule